// File: doc/BRIEF.md
# ADC channel interrupt status logic

This block holds the interrupt status word for one channel of a sequenced analog-to-digital converter. It watches single-cycle event strobes from the scan sequencer and turns them into sticky status bits. The events are group scan complete, group scan preempted, range condition met, pulse counter expired, and result-valid with its data-pickup acknowledge. It also detects overflow: an event that finds its earlier flag still pending, or a result that is not picked up in time, sets an overflow bit.

Software clears bits with a write-one-to-clear port. The status word is always readable. A registered interrupt line is the OR of the status bits that the mask input enables. The group flags can be set only when a configuration input marks this channel as the last channel of its group. A mode input selects whether the channel reports range events or pulse events.

Top module: `adc_ch_irq_status`

## Requirements
- R1: After reset, `status` is 0 and `irq` is 0.
- R2: Status bit positions are fixed: group-done at bit 0, group-cancelled at bit 1, group-overflow at bit 2, range at bit 8, pulse at bit 9 and channel-overflow at bit 10. Every other bit reads 0.
- R3: A `wr_en` cycle clears each status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 keep their value. The change is visible after the clock edge.
- R4: While `last_in_group` is 0, `ev_grp_done` and `ev_grp_cancel` set no status bit.
- R5: While `last_in_group` is 1, `ev_grp_done` sets bit 0 and `ev_grp_cancel` sets bit 1. When both strobes arrive in the same cycle, both bits are set.
- R6: `ev_grp_done` on the last channel sets bit 2 when bit 0 is already 1 at that edge.
- R7: With `pulse_mode` = 0, `ev_range` sets bit 8 and `ev_pulse` is ignored. With `pulse_mode` = 1, `ev_pulse` sets bit 9 and `ev_range` is ignored.
- R8: An accepted range or pulse event whose own bit is already 1 also sets bit 10.
- R9: `ev_res_valid` marks a result as awaiting pickup, and `ev_pickup_ack` removes that mark. Bit 10 is set when `ev_res_valid` arrives while a result is still awaiting pickup and no acknowledge arrives in the same cycle. When valid and acknowledge arrive together, the acknowledge applies to the older result.
- R10: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends at 1.
- R11: `irq` equals the OR of (`status` AND `irq_mask`), sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| last_in_group | input | 1 | Channel is last of its group; enables group flags |
| pulse_mode | input | 1 | 0: report range events, 1: report pulse events |
| ev_grp_done | input | 1 | Group scan completed strobe |
| ev_grp_cancel | input | 1 | Group scan preempted and abandoned strobe |
| ev_range | input | 1 | Range condition met strobe |
| ev_pulse | input | 1 | Pulse counter expired strobe |
| ev_res_valid | input | 1 | New result valid strobe |
| ev_pickup_ack | input | 1 | Data-transfer pickup acknowledge strobe |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write data; 1 bits clear status |
| irq_mask | input | 32 | Interrupt enable mask |
| status | output | 32 | Status word |
| irq | output | 1 | Registered masked interrupt |

## Verification
The pickup-overflow path is hardest to reach, because it depends on a hidden pending flag that only the order of valid and acknowledge strobes controls. The stimulus drives two valid strobes with no acknowledge between them. It then repeats the pattern with an acknowledge placed before the second valid, and again with valid and acknowledge in the same cycle, and checks bit 10 each time. Collisions between a hardware set and a software clear in the same cycle are forced by pairing an event strobe with a clearing write on the same edge.

// File: rtl/adc_ch_irq_status.sv
module adc_ch_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         last_in_group,
  input  logic         pulse_mode,
  input  logic         ev_grp_done,
  input  logic         ev_grp_cancel,
  input  logic         ev_range,
  input  logic         ev_pulse,
  input  logic         ev_res_valid,
  input  logic         ev_pickup_ack,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] irq_mask,
  output logic [W-1:0] status,
  output logic         irq
);
  localparam int B_GD = 0;
  localparam int B_GC = 1;
  localparam int B_GO = 2;
  localparam int B_RG = 8;
  localparam int B_PL = 9;
  localparam int B_CO = 10;

  logic gd_q, gc_q, go_q, rg_q, pl_q, co_q, pend_q;
  logic set_gd, set_gc, set_go, set_rg, set_pl, set_co;
  logic [W-1:0] clr;

  assign clr    = wr_en ? wr_data : '0;
  assign set_gd = last_in_group & ev_grp_done;
  assign set_gc = last_in_group & ev_grp_cancel;
  assign set_go = set_gd & gd_q;
  assign set_rg = ~pulse_mode & ev_range;
  assign set_pl = pulse_mode & ev_pulse;
  assign set_co = (set_rg & rg_q) | (set_pl & pl_q)
                | (ev_res_valid & pend_q & ~ev_pickup_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gd_q <= 1'b0; gc_q <= 1'b0; go_q <= 1'b0;
      rg_q <= 1'b0; pl_q <= 1'b0; co_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gd_q <= set_gd | (gd_q & ~clr[B_GD]);
      gc_q <= set_gc | (gc_q & ~clr[B_GC]);
      go_q <= set_go | (go_q & ~clr[B_GO]);
      rg_q <= set_rg | (rg_q & ~clr[B_RG]);
      pl_q <= set_pl | (pl_q & ~clr[B_PL]);
      co_q <= set_co | (co_q & ~clr[B_CO]);
      if (ev_res_valid)       pend_q <= 1'b1;
      else if (ev_pickup_ack) pend_q <= 1'b0;
    end
  end

  always_comb begin
    status       = '0;
    status[B_GD] = gd_q;
    status[B_GC] = gc_q;
    status[B_GO] = go_q;
    status[B_RG] = rg_q;
    status[B_PL] = pl_q;
    status[B_CO] = co_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & irq_mask);
  end

  // R4
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_in_group |=> ((status[2:0] & ~$past(status[2:0])) == 3'b000));

  // R6
  grp_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_in_group && ev_grp_done && status[B_GD]) |=> status[B_GO]);

  // R7
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_mode |=> !(status[B_RG] && !$past(status[B_RG])));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_range && !pulse_mode && wr_en && wr_data[B_RG]) |=> status[B_RG]);

  // R9
  pickup_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_res_valid && pend_q && !ev_pickup_ack) |=> status[B_CO]);
endmodule

// File: tb/adc_ch_irq_status_tb.sv
module adc_ch_irq_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic last_in_group = 1'b0, pulse_mode = 1'b0;
  logic ev_grp_done = 1'b0, ev_grp_cancel = 1'b0, ev_range = 1'b0, ev_pulse = 1'b0;
  logic ev_res_valid = 1'b0, ev_pickup_ack = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, irq_mask = '0;
  logic [31:0] status;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_ch_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .last_in_group(last_in_group), .pulse_mode(pulse_mode),
    .ev_grp_done(ev_grp_done), .ev_grp_cancel(ev_grp_cancel), .ev_range(ev_range),
    .ev_pulse(ev_pulse), .ev_res_valid(ev_res_valid), .ev_pickup_ack(ev_pickup_ack),
    .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask), .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ev_grp_done = 0; ev_grp_cancel = 0; ev_range = 0; ev_pulse = 0;
    ev_res_valid = 0; ev_pickup_ack = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = '1; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_group();
    last_in_group = 1;
    ev_grp_done = 1; tick();
    chk("R5 done", status, 32'h1);
    ev_grp_done = 1; tick();
    chk("R6 overflow", status, 32'h5);
    wr_en = 1; wr_data = 32'h0; tick();
    chk("R3 write zero", status, 32'h5);
    wr_en = 1; wr_data = 32'h4; tick();
    chk("R3 partial clear", status, 32'h1);
    clear_all();
    chk("R3 clear", status, 32'h0);
    last_in_group = 0;
    ev_grp_done = 1; ev_grp_cancel = 1; tick();
    chk("R4 gated", status, 32'h0);
    last_in_group = 1;
    ev_grp_done = 1; ev_grp_cancel = 1; tick();
    chk("R5 both", status, 32'h3);
    clear_all();
  endtask

  task automatic t_chan();
    pulse_mode = 0;
    ev_range = 1; tick();
    chk("R7 range", status, 32'h100);
    ev_pulse = 1; tick();
    chk("R7 pulse ignored", status, 32'h100);
    ev_range = 1; tick();
    chk("R8 range repeat", status, 32'h500);
    pulse_mode = 1;
    ev_pulse = 1; tick();
    chk("R2 layout", status, 32'h700);
    chk("R2 unused zero", status & 32'hFFFF_F8F8, 32'h0);
    clear_all();
    ev_pulse = 1; tick();
    chk("R7 pulse", status, 32'h200);
    ev_range = 1; tick();
    chk("R7 range ignored", status, 32'h200);
    ev_pulse = 1; tick();
    chk("R8 pulse repeat", status, 32'h600);
    clear_all();
    pulse_mode = 0;
  endtask

  task automatic t_pickup();
    ev_res_valid = 1; tick();
    chk("R9 first valid", status, 32'h0);
    ev_res_valid = 1; tick();
    chk("R9 no ack", status, 32'h400);
    clear_all();
    ev_pickup_ack = 1; tick();
    ev_res_valid = 1; tick();
    chk("R9 acked", status, 32'h0);
    ev_res_valid = 1; ev_pickup_ack = 1; tick();
    chk("R9 same cycle ack", status, 32'h0);
    ev_pickup_ack = 1; tick();
    clear_all();
  endtask

  task automatic t_setwins();
    ev_range = 1; tick();
    ev_range = 1; wr_en = 1; wr_data = 32'h100; tick();
    chk("R10 set wins", status, 32'h500);
    clear_all();
  endtask

  task automatic t_irq();
    irq_mask = 32'h100;
    ev_range = 1; tick();
    chk("R11 irq delayed", {31'b0, irq}, 32'h0);
    tick();
    chk("R11 irq set", {31'b0, irq}, 32'h1);
    irq_mask = 32'h200; tick();
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    clear_all();
  endtask

  initial begin
    #45 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_group();
    t_chan();
    t_pickup();
    t_setwins();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule